// File: doc/BRIEF.md
# Flash Card Write-Data Block Receiver

This block sits on the device side of a managed flash card link and takes in the data blocks that a host writes. It watches up to eight data lines. It can run them as one, four or eight lines, and it can take one bit per line per clock or two. The second sample of a clock arrives already separated on its own input vector. After the block sees a low start bit, it rebuilds each byte of a fixed-size block and passes the bytes on at once. At the same time it runs one CRC16 per active line. In two-sample mode it runs a second, independent CRC16 per line for the odd-numbered bytes.

After the data come the check words and a closing high bit. The block checks all of them and forms one verdict: pass or fail. Two clocks after the closing bit it drives a three-bit status token on line 0, framed by a low start bit and a high end bit. It then holds line 0 low as a busy signal for a programmable number of clocks, and only after that does it listen for the next block. The byte consumer gets a one-cycle done strobe with the same verdict and must drop the block's bytes when the verdict is fail.

Top module: `emmc_wr_rx`

## Requirements
- R1: While idle, the receiver waits for a 0 on the rising-edge sample of line 0 and treats that clock as the start bit. The width and rate inputs are captured on that clock.
- R2: Width code 0 uses line 0 only, with the MSB of each byte first. Code 1 uses lines 0-3: the high nibble comes first, then the low nibble, with bit k of the nibble on line k. Codes 2 and 3 use all eight lines, with byte bit k on line k in a single bit-time.
- R3: In single-rate mode only the rising sample is used. All BLOCK_BYTES bytes (default 512) appear in order on slot 0 (bo_data[7:0] with bo_valid[0]), one clock after the clock that carried the last bit-time of each byte.
- R4: In dual-rate mode the rising samples carry bytes 0, 2, 4 and so on, and the falling samples carry bytes 1, 3, 5 and so on. Each pair appears on the same cycle: the even byte on slot 0 and the odd byte on slot 1 (bo_data[15:8] with bo_valid[1]).
- R5: Every active line has its own CRC16 (polynomial 0x1021, start value 0) over the bits that line carried. The received words follow the data on 16 clocks, MSB first. In dual-rate mode the rising samples carry the even-byte CRC and the falling samples carry the odd-byte CRC.
- R6: On the clock after the last CRC clock, every active line must read 1 on the rising sample. A 0 on any active line counts as a failure.
- R7: The clock after the closing bit, line 0 is not driven. Then line 0 is driven with 0, then the status bits 010 (pass) or 101 (fail) MSB first, then 1. After that it is held at 0 for busy_cycles clocks, a value captured on the closing-bit clock, and then released.
- R8: blk_done pulses for one cycle, one clock after the closing-bit clock. blk_ok is high only if every CRC matched and the closing bit was good.
- R9: Changes on the width and rate inputs after the start bit have no effect on the block in progress.
- R10: No start bit is accepted while the status token or busy period is in progress. Line 0 is driven only during that period.
- R11: A synchronous reset stops any block in progress and clears all outputs. The receiver then waits for a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_ddr | input | 1 | 1 = two samples per clock |
| cfg_width | input | 2 | Line count code (0: one, 1: four, 2/3: eight) |
| busy_cycles | input | BUSY_W | Clocks of low busy after the status token |
| dat_rise | input | 8 | Data lines sampled at the rising edge |
| dat_fall | input | 8 | Data lines sampled at the falling edge |
| dat0_o | output | 1 | Value driven on line 0 |
| dat0_oe | output | 1 | Drive enable for line 0 |
| bo_valid | output | 2 | Byte strobes: bit 0 even/only slot, bit 1 odd slot |
| bo_data | output | 16 | Byte slots: [7:0] slot 0, [15:8] slot 1 |
| blk_done | output | 1 | One-cycle pulse at block end |
| blk_ok | output | 1 | Verdict qualified by blk_done |

## Verification
A wrong bit-time or byte counter does not stay hidden. It shows up within the first few bytes as misordered data, or at the end as the wrong byte count or a status token on the wrong cycle. A CRC lane that is mis-enabled or mis-cleared turns a good block into a 101 token, or a corrupted one into 010, exactly two clocks after the closing bit. A receiver that leaves its wait state too early is caught when line 0 is held low during the busy period, because it then starts a bogus block and spoils the next block's verdict.

// File: rtl/emmc_wrx_pkg.sv
package emmc_wrx_pkg;

  localparam int LANES = 8;

  typedef enum logic [2:0] {RX_IDLE, RX_DATA, RX_CRC, RX_END, RX_WAIT} rx_st_e;
  typedef enum logic [2:0] {TX_IDLE, TX_TURN, TX_START, TX_S2, TX_S1, TX_S0,
                            TX_END, TX_BUSY} tx_st_e;

  // One serial step of the x^16 + x^12 + x^5 + 1 checksum.
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] w);
    case (w)
      2'd0:    return 8'h01;
      2'd1:    return 8'h0F;
      default: return 8'hFF;
    endcase
  endfunction

  // Index of the last bit-time of a byte (bit-times per byte minus one).
  function automatic logic [2:0] bt_last(input logic [1:0] w);
    case (w)
      2'd0:    return 3'd7;
      2'd1:    return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [1:0] bt_shift(input logic [1:0] w);
    case (w)
      2'd0:    return 2'd3;
      2'd1:    return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  // Shift one bit-time of line samples into a partial byte.
  function automatic logic [7:0] pack_shift(input logic [7:0] sh, input logic [7:0] d,
                                            input logic [1:0] w);
    case (w)
      2'd0:    return {sh[6:0], d[0]};
      2'd1:    return {sh[3:0], d[3:0]};
      default: return d;
    endcase
  endfunction

endpackage

// File: rtl/emmc_wrx_crc_lane.sv
module emmc_wrx_crc_lane
  import emmc_wrx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic calc,
  input  logic chk,
  input  logic din,
  output logic mism
);
  logic [15:0] crc;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      crc  <= '0;
      mism <= 1'b0;
    end else if (calc) begin
      crc <= crc16_step(crc, din);
    end else if (chk) begin
      mism <= mism | (din ^ crc[15]);
      crc  <= {crc[14:0], 1'b0};
    end
  end

  // R5: a lane is never accumulating and comparing in the same clock
  p_calc_chk_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(calc && chk));
endmodule

// File: rtl/emmc_wrx_packer.sv
module emmc_wrx_packer
  import emmc_wrx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       last,
  input  logic [1:0] width,
  input  logic [7:0] din,
  output logic       valid,
  output logic [7:0] dout
);
  logic [7:0] sh;
  logic [7:0] nxt;

  assign nxt = pack_shift(sh, din, width);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh    <= '0;
      valid <= 1'b0;
      dout  <= '0;
    end else begin
      valid <= en && last;
      if (en) sh <= nxt;
      if (en && last) dout <= nxt;
    end
  end
endmodule

// File: rtl/emmc_wrx_status_tx.sv
module emmc_wrx_status_tx
  import emmc_wrx_pkg::*;
#(
  parameter int BUSY_W = 8
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              pass,
  input  logic [BUSY_W-1:0] busy_len,
  output logic              dat0_o,
  output logic              dat0_oe,
  output logic              active
);
  tx_st_e            st;
  logic [2:0]        pat;
  logic [BUSY_W-1:0] blen_q;
  logic [BUSY_W-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= TX_IDLE;
      pat    <= '0;
      blen_q <= '0;
      bcnt   <= '0;
    end else begin
      case (st)
        TX_IDLE: if (go) begin
          st     <= TX_TURN;
          pat    <= pass ? 3'b010 : 3'b101;
          blen_q <= busy_len;
        end
        TX_TURN:  st <= TX_START;
        TX_START: st <= TX_S2;
        TX_S2:    st <= TX_S1;
        TX_S1:    st <= TX_S0;
        TX_S0:    st <= TX_END;
        TX_END: begin
          if (blen_q == '0) st <= TX_IDLE;
          else begin
            st   <= TX_BUSY;
            bcnt <= blen_q;
          end
        end
        TX_BUSY: begin
          bcnt <= bcnt - 1'b1;
          if (bcnt == BUSY_W'(1)) st <= TX_IDLE;
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  always_comb begin
    dat0_oe = 1'b0;
    dat0_o  = 1'b0;
    case (st)
      TX_START: dat0_oe = 1'b1;
      TX_S2:    begin dat0_oe = 1'b1; dat0_o = pat[2]; end
      TX_S1:    begin dat0_oe = 1'b1; dat0_o = pat[1]; end
      TX_S0:    begin dat0_oe = 1'b1; dat0_o = pat[0]; end
      TX_END:   begin dat0_oe = 1'b1; dat0_o = 1'b1;   end
      TX_BUSY:  dat0_oe = 1'b1;
      default:  ;
    endcase
  end

  assign active = (st != TX_IDLE);

  // R7: middle status bit always differs from the one before it
  p_token_alt_r7: assert property (@(posedge clk) disable iff (rst)
    (st == TX_S1) |-> (dat0_o != $past(dat0_o)));
  // R7: one undriven clock precedes the token start bit
  p_turn_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (st == TX_START) |-> !$past(dat0_oe));
  // R7: busy period never runs with an exhausted count
  p_busy_count_r7: assert property (@(posedge clk) disable iff (rst)
    (st == TX_BUSY) |-> (bcnt != '0));
endmodule

// File: rtl/emmc_wr_rx.sv
module emmc_wr_rx
  import emmc_wrx_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int BUSY_W      = 8
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_ddr,
  input  logic [1:0]        cfg_width,
  input  logic [BUSY_W-1:0] busy_cycles,
  input  logic [7:0]        dat_rise,
  input  logic [7:0]        dat_fall,
  output logic              dat0_o,
  output logic              dat0_oe,
  output logic [1:0]        bo_valid,
  output logic [15:0]       bo_data,
  output logic              blk_done,
  output logic              blk_ok
);
  localparam int CW = $clog2(BLOCK_BYTES * 8);
  localparam logic [CW:0] FULL_B = (CW+1)'(BLOCK_BYTES);
  localparam logic [CW:0] HALF_B = (CW+1)'(BLOCK_BYTES / 2);

  rx_st_e      st;
  logic        ddr_q;
  logic [1:0]  w_q;
  logic [CW-1:0] dcnt;
  logic [3:0]  ccnt;
  logic [CW:0] dlast;
  logic        start_seen, in_data, in_crc, byte_last, data_last;
  logic        crc_err, end_ok, go, tx_active;
  logic [LANES-1:0] lmask;
  logic [1:0][LANES-1:0] mism_v;
  logic [1:0][7:0] samp;

  assign samp       = {dat_fall, dat_rise};
  assign lmask      = lane_mask(w_q);
  assign start_seen = (st == RX_IDLE) && !dat_rise[0];
  assign in_data    = (st == RX_DATA);
  assign in_crc     = (st == RX_CRC);
  assign byte_last  = (dcnt[2:0] & bt_last(w_q)) == bt_last(w_q);
  assign dlast      = ((ddr_q ? HALF_B : FULL_B) << bt_shift(w_q)) - 1'b1;
  assign data_last  = ({1'b0, dcnt} == dlast);
  assign crc_err    = |mism_v;
  assign end_ok     = &(dat_rise | ~lmask);
  assign go         = (st == RX_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= RX_IDLE;
      ddr_q    <= 1'b0;
      w_q      <= '0;
      dcnt     <= '0;
      ccnt     <= '0;
      blk_done <= 1'b0;
      blk_ok   <= 1'b0;
    end else begin
      blk_done <= go;
      blk_ok   <= go && !crc_err && end_ok;
      case (st)
        RX_IDLE: begin
          ddr_q <= cfg_ddr;
          w_q   <= cfg_width;
          dcnt  <= '0;
          if (start_seen) st <= RX_DATA;
        end
        RX_DATA: begin
          dcnt <= dcnt + 1'b1;
          if (data_last) begin
            st   <= RX_CRC;
            ccnt <= '0;
          end
        end
        RX_CRC: begin
          ccnt <= ccnt + 1'b1;
          if (ccnt == 4'd15) st <= RX_END;
        end
        RX_END:  st <= RX_WAIT;
        RX_WAIT: if (!tx_active) st <= RX_IDLE;
        default: st <= RX_IDLE;
      endcase
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_ph
    logic ph_on;
    assign ph_on = (p == 0) | ddr_q;
    for (genvar i = 0; i < LANES; i++) begin : g_ln
      emmc_wrx_crc_lane u_lane (
        .clk  (clk),
        .rst  (rst),
        .clr  (start_seen),
        .calc (in_data & ph_on & lmask[i]),
        .chk  (in_crc & ph_on & lmask[i]),
        .din  (samp[p][i]),
        .mism (mism_v[p][i])
      );
    end
    emmc_wrx_packer u_pack (
      .clk   (clk),
      .rst   (rst),
      .en    (in_data & ph_on),
      .last  (byte_last),
      .width (w_q),
      .din   (samp[p]),
      .valid (bo_valid[p]),
      .dout  (bo_data[8*p +: 8])
    );
  end

  emmc_wrx_status_tx #(.BUSY_W(BUSY_W)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .pass     (!crc_err && end_ok),
    .busy_len (busy_cycles),
    .dat0_o   (dat0_o),
    .dat0_oe  (dat0_oe),
    .active   (tx_active)
  );

  // Byte tally used only by the assertions below.
  logic [CW:0] nbytes;
  always_ff @(posedge clk) begin
    if (rst || start_seen) nbytes <= '0;
    else nbytes <= nbytes + (CW+1)'(bo_valid[0]) + (CW+1)'(bo_valid[1]);
  end

  // R3: every block hands over exactly BLOCK_BYTES bytes before its verdict
  p_byte_count_r3: assert property (@(posedge clk) disable iff (rst)
    (st == RX_END) |-> (nbytes == FULL_B));
  // R3: byte strobes only follow data clocks
  p_bytes_in_data_r3: assert property (@(posedge clk) disable iff (rst)
    (|bo_valid) |-> ($past(st) == RX_DATA));
  // R8: verdict strobe follows the closing-bit clock
  p_done_after_end_r8: assert property (@(posedge clk) disable iff (rst)
    blk_done |-> ($past(st) == RX_END));
  // R9: captured configuration holds while a block is in progress
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
    ((st != RX_IDLE) && ($past(st) != RX_IDLE)) |-> ($stable(ddr_q) && $stable(w_q)));
  // R10: line 0 is driven only while the receiver waits out the token
  p_oe_in_wait_r10: assert property (@(posedge clk) disable iff (rst)
    dat0_oe |-> (st == RX_WAIT));
endmodule

// File: tb/tb_emmc_wr_rx.sv
module tb_emmc_wr_rx;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_ddr = 1'b0;
  logic [1:0] cfg_width = 2'd0;
  logic [7:0] busy_cycles = 8'd0;
  logic [7:0] dat_rise = 8'hFF;
  logic [7:0] dat_fall = 8'hFF;
  logic dat0_o, dat0_oe, blk_done, blk_ok;
  logic [1:0] bo_valid;
  logic [15:0] bo_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  emmc_wr_rx dut (
    .clk(clk), .rst(rst), .cfg_ddr(cfg_ddr), .cfg_width(cfg_width),
    .busy_cycles(busy_cycles), .dat_rise(dat_rise), .dat_fall(dat_fall),
    .dat0_o(dat0_o), .dat0_oe(dat0_oe), .bo_valid(bo_valid), .bo_data(bo_data),
    .blk_done(blk_done), .blk_ok(blk_ok)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] blk [NB];
  logic [7:0] got [NB];
  int nrx;
  logic s_oe, s_o, s_done, s_ok;
  logic [1:0] s_bv;

  // fields: [11] ddr, [10:9] width, [8] bad crc, [7] bad end, [6] cfg twist, [5:0] busy
  localparam int NV = 10;
  localparam logic [11:0] VECS [NV] = '{
    {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 6'd3},
    {1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 6'd0},
    {1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 6'd5},
    {1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 6'd2},
    {1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 6'd1},
    {1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 6'd4},
    {1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 6'd2},
    {1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 6'd1},
    {1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 6'd3},
    {1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 6'd0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic step(input logic [7:0] r, input logic [7:0] f);
    @(negedge clk);
    s_oe = dat0_oe; s_o = dat0_o; s_done = blk_done; s_ok = blk_ok; s_bv = bo_valid;
    if (bo_valid[0]) begin if (nrx < NB) got[nrx] = bo_data[7:0]; nrx++; end
    if (bo_valid[1]) begin if (nrx < NB) got[nrx] = bo_data[15:8]; nrx++; end
    dat_rise = r; dat_fall = f;
  endtask

  function automatic int lanes_of(input logic [1:0] w);
    return (w == 2'd0) ? 1 : (w == 2'd1) ? 4 : 8;
  endfunction

  // Bit carried by line ln on bit-time c of stream ph.
  function automatic logic line_bit(input int ph, input int ln, input int c,
                                    input bit ddr, input logic [1:0] w);
    int wl = lanes_of(w);
    int bt = 8 / wl;
    int s = c / bt;
    int t = c % bt;
    int idx = ddr ? (2 * s + ph) : s;
    return blk[idx][(bt - 1 - t) * wl + ln];
  endfunction

  function automatic logic [15:0] lane_crc(input int ph, input int ln, input bit ddr,
                                           input logic [1:0] w);
    logic [15:0] c = 16'h0;
    int nclk = (ddr ? NB / 2 : NB) * (8 / lanes_of(w));
    for (int k = 0; k < nclk; k++) begin
      logic b = line_bit(ph, ln, k, ddr, w);
      c = {c[14:0], 1'b0} ^ ({16{c[15] ^ b}} & 16'h1021);
    end
    return c;
  endfunction

  task automatic send_block(input bit ddr, input logic [1:0] w, input int seed,
                            input bit crc_bad, input bit end_bad, input int busy,
                            input bit twist, input bit hold_low, input string req);
    logic [15:0] crcv [2][8];
    int wl = lanes_of(w);
    int nclk = (ddr ? NB / 2 : NB) * (8 / wl);
    bit expect_ok = !crc_bad && !end_bad;
    bit tok_ok = 1'b1;
    int bad_bytes = 0;
    logic [2:0] pat = expect_ok ? 3'b010 : 3'b101;
    logic [7:0] r, f;
    for (int k = 0; k < NB; k++) blk[k] = 8'((k * 37 + seed * 11 + (k >> 4)) & 255);
    for (int p = 0; p < 2; p++)
      for (int ln = 0; ln < 8; ln++)
        crcv[p][ln] = (ln < wl && (p == 0 || ddr)) ? lane_crc(p, ln, ddr, w) : 16'h0;
    if (crc_bad) begin
      if (ddr) crcv[1][0][9] = ~crcv[1][0][9];
      else     crcv[0][wl-1][4] = ~crcv[0][wl-1][4];
    end
    cfg_ddr = ddr; cfg_width = w; busy_cycles = 8'(busy);
    nrx = 0;
    step(8'hFF, 8'hFF);
    step(8'hFF, 8'hFF);
    step(8'h00, 8'hFF);
    for (int c = 0; c < nclk; c++) begin
      r = 8'hFF; f = 8'hFF;
      for (int ln = 0; ln < wl; ln++) begin
        r[ln] = line_bit(0, ln, c, ddr, w);
        if (ddr) f[ln] = line_bit(1, ln, c, ddr, w);
      end
      step(r, f);
      if (twist && c == 0) begin cfg_ddr = ~ddr; cfg_width = w + 2'd1; end
    end
    for (int j = 0; j < 16; j++) begin
      r = 8'hFF; f = 8'hFF;
      for (int ln = 0; ln < wl; ln++) begin
        r[ln] = crcv[0][ln][15 - j];
        if (ddr) f[ln] = crcv[1][ln][15 - j];
      end
      step(r, f);
    end
    r = 8'hFF;
    if (end_bad) r[wl-1] = 1'b0;
    step(r, 8'hFF);
    for (int k = 1; k <= 10 + busy; k++) begin
      step((hold_low && k <= 6 + busy) ? 8'h00 : 8'hFF, 8'hFF);
      if (k == 1) begin
        chk(s_done === 1'b1, req, "R8 done strobe", int'(s_done), 1);
        chk(s_ok === expect_ok, req, "R8 verdict", int'(s_ok), int'(expect_ok));
        if (s_oe !== 1'b0) tok_ok = 1'b0;
      end else if (k == 2) begin
        if (s_oe !== 1'b1 || s_o !== 1'b0) tok_ok = 1'b0;
      end else if (k <= 5) begin
        if (s_oe !== 1'b1 || s_o !== pat[5 - k]) tok_ok = 1'b0;
      end else if (k == 6) begin
        if (s_oe !== 1'b1 || s_o !== 1'b1) tok_ok = 1'b0;
      end else if (k <= 6 + busy) begin
        if (s_oe !== 1'b1 || s_o !== 1'b0) tok_ok = 1'b0;
      end else if (s_oe !== 1'b0) tok_ok = 1'b0;
    end
    chk(tok_ok, req, "R7 status token and busy window", int'(tok_ok), 1);
    chk(nrx == NB, req, "R3 byte count", nrx, NB);
    for (int k = 0; k < NB; k++) if (got[k] !== blk[k]) bad_bytes++;
    chk(bad_bytes == 0, req, "R2/R4 byte values and order", bad_bytes, 0);
    cfg_ddr = ddr; cfg_width = w;
  endtask

  initial begin
    bit quiet;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R11 / R1: after reset with idle-high lines nothing is produced
    quiet = 1'b1;
    for (int k = 0; k < 20; k++) begin
      step(8'hFF, 8'hFF);
      if (s_oe !== 1'b0 || s_bv !== 2'b00 || s_done !== 1'b0) quiet = 1'b0;
    end
    chk(quiet, "R11", "R1 idle outputs after reset", int'(quiet), 1);

    // Vector table walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      logic [11:0] e = VECS[v];
      send_block(e[11], e[10:9], v + 1, e[8], e[7], int'(e[5:0]), e[6], 1'b0, "R5/R6");
    end

    // R10: line 0 held low during the token must not start a block
    send_block(1'b0, 2'd2, 21, 1'b0, 1'b0, 4, 1'b0, 1'b1, "R10");
    send_block(1'b1, 2'd2, 22, 1'b0, 1'b0, 1, 1'b0, 1'b0, "R10");

    // R11: reset in the middle of a block, then a clean block
    cfg_ddr = 1'b0; cfg_width = 2'd1;
    step(8'hFF, 8'hFF);
    step(8'h00, 8'hFF);
    for (int c = 0; c < 30; c++) step(8'(c * 13), 8'hFF);
    rst = 1'b1;
    step(8'hFF, 8'hFF);
    rst = 1'b0;
    step(8'hFF, 8'hFF);
    chk(s_oe === 1'b0 && s_bv === 2'b00 && s_done === 1'b0, "R11",
        "outputs cleared by mid-block reset", int'(s_bv), 0);
    send_block(1'b0, 2'd1, 33, 1'b0, 1'b0, 2, 1'b0, 1'b0, "R11");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule